// File: doc/BRIEF.md
# Glitch-Free Output Bank Disable Controller

This block decides, for each output clock bank of a clock buffer, whether the bank's clock reaches its pins and whether the pins are driven at all. Every bank has its own disable input. One shared three-level mode input, carried on two wires, selects what a disable does. It can float the pins, or it can stop the clock cleanly with the pins held low. A third level of the mode input puts the block in a test mode. The pad tri-state cells and the clock sources sit outside the block. They are fed by the block's per-bank clock gate output and drive-enable output.

In test mode the bank disables are ignored. The last bank's disable input instead starts a test reset. Every bank floats at once. Once the reference clock has shown a fixed number of rising edges, a hold output freezes the surrounding state machines in a known state. Both effects last until that disable input falls, and normal test operation then resumes.

Everything runs in the output clock domain. The disable inputs and the reference clock arrive asynchronously and are synchronized inside the block. The per-bank source clocks are levels that change on output clock edges.

Top module: `bank_clk_ctrl`

## Requirements
- R1: While reset is asserted, every drive enable is 1, every gated bank clock is 0 and the hold output is 0.
- R2: With a bank's disable low and mode not in test, that bank's drive enable is 1 and its gated clock equals the bank's source clock delayed by one output clock cycle.
- R3: With mode code 2'b10 (float) and a bank's disable high, that bank's drive enable goes to 0 and the bank's clock gate is left untouched.
- R4: With mode code 2'b00 (hold-off) and a bank's disable high, the drive enable stays 1. The gated clock stops only at a falling edge of the source, so no high phase is ever shortened, and it then stays low.
- R5: In hold-off, the gated clock shows its last high level no later than six source clock periods after the disable input rises.
- R6: When a bank leaves hold-off, its gated clock restarts only at a rising edge of the source, so the first pulse after the restart is a full high phase.
- R7: Mode codes 2'b01 and 2'b11 select test mode. In test mode the disable inputs of all banks except the last have no effect on drive enable or gated clock.
- R8: In test mode, a high on the last bank's disable input drives every bank's drive enable to 0.
- R9: In test mode with the last disable high, the hold output rises after the fifth synchronized rising edge of the reference clock and not before. Further edges leave it high.
- R10: The hold output and the floated banks remain until the last disable input falls. The hold output and the edge count then clear, and the drive enables return to 1.
- R11: Each disable input passes through two synchronizing flip-flops. A change on a disable input reaches the drive enable on the third rising output clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output clock domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Three-level mode: 00 hold-off, 10 float, 01 or 11 test |
| bank_dis_i | input | NUM_BANKS | Asynchronous disable per bank, high disables |
| ref_clk_i | input | 1 | Asynchronous reference clock whose rising edges are counted in test reset |
| src_clk_i | input | NUM_BANKS | Per-bank source clock level, synchronous to clk |
| bank_clk_o | output | NUM_BANKS | Per-bank gated clock toward the pad |
| drive_en_o | output | NUM_BANKS | Per-bank pad drive enable, 0 floats the pins |
| fsm_hold_o | output | 1 | Holds the surrounding state machines in their fixed state |

## Verification
The hardest case to reach is a hold-off request that arrives just as a long source high phase begins. The stop then has to wait out the whole phase after the two synchronizer cycles, and the restart has to wait for the next rising source edge. The stimulus first aligns itself to the start of a three-cycle high phase on the slower bank, then raises the disable. It records the last high output cycle and the length of the first pulse after re-enable. The test reset count is reached with slow, spaced reference pulses, so the four-edge and five-edge points can be observed separately, and the count is then re-armed after a release to show that it cleared.

// File: rtl/bank_clk_pkg.sv
package bank_clk_pkg;

  typedef enum logic [1:0] {
    MODE_HOLDOFF   = 2'b00,
    MODE_TEST      = 2'b01,
    MODE_FLOAT     = 2'b10,
    MODE_TEST_OPEN = 2'b11
  } ctrl_mode_e;

  // Both codes with bit 0 set mean the pin is left open: test mode.
  function automatic logic f_is_test(input logic [1:0] mode);
    return mode[0];
  endfunction

  function automatic logic f_want_holdoff(input logic dis, input logic [1:0] mode);
    return dis && (mode == MODE_HOLDOFF);
  endfunction

  function automatic logic f_want_float(input logic dis, input logic [1:0] mode);
    return dis && (mode == MODE_FLOAT);
  endfunction

  // Gate state may only change while the source is low.
  function automatic logic f_run_next(input logic run, input logic src, input logic stop);
    return src ? run : !stop;
  endfunction

  // Saturating counter step; clears when not armed.
  function automatic int unsigned f_count_next(input int unsigned cnt, input logic arm,
                                               input logic edge_seen, input int unsigned limit);
    if (!arm) return 0;
    if (edge_seen && (cnt < limit)) return cnt + 1;
    return cnt;
  endfunction

endpackage

// File: rtl/bank_disable_sync.sv
module bank_disable_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/ref_edge_counter.sv
module ref_edge_counter
  import bank_clk_pkg::*;
#(
  parameter int REF_EDGES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk_i,
  input  logic arm_i,
  output logic edge_o,
  output logic hold_o
);

  localparam int CNT_W = $clog2(REF_EDGES + 1);

  logic [2:0]       ref_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= {ref_q[1:0], ref_clk_i};
  end

  assign edge_o = ref_q[1] & ~ref_q[2];
  assign cnt_d  = CNT_W'(f_count_next(int'(cnt_q), arm_i, edge_o, REF_EDGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hold_o = (int'(cnt_q) == REF_EDGES);

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= REF_EDGES); // R9
  AST_HOLD_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> $past(edge_o) && $past(arm_i)); // R9
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> !hold_o); // R10

endmodule

// File: rtl/bank_gate.sv
module bank_gate
  import bank_clk_pkg::*;
#(
  parameter int STOP_LIMIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_clk_i,
  input  logic stop_req_i,
  input  logic float_req_i,
  input  logic test_mode_i,
  input  logic test_float_i,
  output logic bank_clk_o,
  output logic drive_en_o
);

  localparam int WIN_W = $clog2(STOP_LIMIT + 2);

  logic             run_q;
  logic             run_d;
  logic             src_q;
  logic             src_rise;
  logic             stop_pending;
  logic [WIN_W-1:0] win_q;

  assign run_d = f_run_next(run_q, src_clk_i, stop_req_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b1;
      bank_clk_o <= 1'b0;
      drive_en_o <= 1'b1;
      src_q      <= 1'b0;
    end else begin
      run_q      <= run_d;
      bank_clk_o <= src_clk_i & run_d;
      drive_en_o <= test_mode_i ? !test_float_i : !float_req_i;
      src_q      <= src_clk_i;
    end
  end

  // Observation window: source rising edges seen while a stop waits.
  assign src_rise     = src_clk_i & ~src_q;
  assign stop_pending = stop_req_i & run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              win_q <= '0;
    else if (!stop_pending)  win_q <= '0;
    else if (src_rise && (int'(win_q) <= STOP_LIMIT)) win_q <= win_q + 1'b1;
  end

  AST_NO_RUNT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bank_clk_o) |-> !$past(src_clk_i)); // R4
  AST_NO_RUNT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bank_clk_o) |-> !$past(src_clk_i, 2)); // R6
  AST_STOP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(win_q) < STOP_LIMIT); // R5
  AST_FLOAT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (float_req_i && !test_mode_i) |=> !drive_en_o); // R3
  AST_TEST_KEEPS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode_i && !test_float_i) |=> drive_en_o); // R7

endmodule

// File: rtl/bank_clk_ctrl.sv
module bank_clk_ctrl
  import bank_clk_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int REF_EDGES   = 5,
  parameter int STOP_LIMIT  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_i,
  input  logic [NUM_BANKS-1:0] bank_dis_i,
  input  logic                 ref_clk_i,
  input  logic [NUM_BANKS-1:0] src_clk_i,
  output logic [NUM_BANKS-1:0] bank_clk_o,
  output logic [NUM_BANKS-1:0] drive_en_o,
  output logic                 fsm_hold_o
);

  localparam int RST_BANK = NUM_BANKS - 1;

  logic [NUM_BANKS-1:0] dis_sync;
  logic [NUM_BANKS-1:0] stop_req;
  logic [NUM_BANKS-1:0] float_req;
  logic                 test_mode;
  logic                 test_float;
  logic                 ref_edge;

  bank_disable_sync #(.WIDTH(NUM_BANKS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (bank_dis_i),
    .sync_o  (dis_sync)
  );

  assign test_mode  = f_is_test(mode_i);
  assign test_float = test_mode & dis_sync[RST_BANK];

  ref_edge_counter #(.REF_EDGES(REF_EDGES)) u_refcnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_clk_i (ref_clk_i),
    .arm_i     (test_float),
    .edge_o    (ref_edge),
    .hold_o    (fsm_hold_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign stop_req[b]  = f_want_holdoff(dis_sync[b], mode_i);
    assign float_req[b] = f_want_float(dis_sync[b], mode_i);

    bank_gate #(.STOP_LIMIT(STOP_LIMIT)) u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .src_clk_i    (src_clk_i[b]),
      .stop_req_i   (stop_req[b]),
      .float_req_i  (float_req[b]),
      .test_mode_i  (test_mode),
      .test_float_i (test_float),
      .bank_clk_o   (bank_clk_o[b]),
      .drive_en_o   (drive_en_o[b])
    );
  end

  AST_TEST_ALL_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    test_float |=> (drive_en_o == '0)); // R8
  AST_HOLD_ONLY_IN_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_hold_o |-> $past(test_float)); // R10
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|stop_req, |float_req, test_mode})); // R7

endmodule

// File: tb/bank_clk_ctrl_tb.sv
module bank_clk_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [1:0] bank_dis = 2'b00;
  logic       ref_clk = 1'b0;
  logic [1:0] src_clk = 2'b00;
  logic [1:0] bank_clk;
  logic [1:0] drive_en;
  logic       fsm_hold;

  int vectors = 0;
  int fails = 0;
  int scnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bank_clk_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode),
    .bank_dis_i (bank_dis),
    .ref_clk_i  (ref_clk),
    .src_clk_i  (src_clk),
    .bank_clk_o (bank_clk),
    .drive_en_o (drive_en),
    .fsm_hold_o (fsm_hold)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, updated at every rising edge.
  logic [1:0] dis_hist [4];
  logic       ref_hist [4];
  int         cnt_m;
  logic [1:0] run_m, clk_m, oe_m;
  logic       hold_m;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin dis_hist[i] = 2'b00; ref_hist[i] = 1'b0; end
      cnt_m = 0; run_m = 2'b11; clk_m = 2'b00; oe_m = 2'b11; hold_m = 1'b0;
    end else begin
      logic [1:0] ds;
      logic       redge, tst;
      for (int i = 3; i > 0; i--) begin dis_hist[i] = dis_hist[i-1]; ref_hist[i] = ref_hist[i-1]; end
      dis_hist[0] = bank_dis;
      ref_hist[0] = ref_clk;
      ds    = dis_hist[2];
      redge = ref_hist[2] && !ref_hist[3];
      tst   = (mode == 2'b01) || (mode == 2'b11);
      for (int b = 0; b < 2; b++) begin
        if (!src_clk[b]) run_m[b] = !(ds[b] && mode == 2'b00);
        clk_m[b] = src_clk[b] && run_m[b];
        oe_m[b]  = tst ? !ds[1] : !(ds[b] && mode == 2'b10);
      end
      if (!(tst && ds[1])) cnt_m = 0;
      else if (redge && cnt_m < 5) cnt_m++;
      hold_m = (cnt_m == 5);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2/R4/R6 bank_clk", bank_clk, clk_m);
      check("R3/R8/R11 drive_en", drive_en, oe_m);
      check("R9/R10 hold", fsm_hold, hold_m);
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      scnt++;
      src_clk = {(scnt % 6) < 3, scnt[0]};
    end
  endtask

  task automatic ref_pulse();
    ref_clk = 1'b1; tick(3);
    ref_clk = 1'b0; tick(3);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int last_high, highs, burst;
    bit seen;
    tick(4);
    check("R1 drive_en in reset", drive_en, 3);
    check("R1 bank_clk in reset", bank_clk, 0);
    check("R1 hold in reset", fsm_hold, 0);
    rst_n = 1'b1;
    tick(30);

    // R2: enabled bank follows its source
    highs = 0;
    for (int k = 0; k < 10; k++) begin tick(1); highs += bank_clk[0]; end
    check("R2 bank0 pulses", highs, 5);
    check("R2 drive_en", drive_en, 3);

    // R4/R5: hold-off aligned to the start of a long high phase
    while ((scnt % 6) != 0) tick(1);
    bank_dis[1] = 1'b1;
    last_high = 0;
    for (int k = 1; k <= 60; k++) begin
      tick(1);
      if (bank_clk[1]) last_high = k;
      check("R4 drive kept in hold-off", drive_en[1], 1);
    end
    check("R5 stop within six periods", int'(last_high <= 36), 1);
    highs = 0;
    for (int k = 0; k < 12; k++) begin tick(1); highs += bank_clk[1]; end
    check("R4 bank1 held low", highs, 0);

    // R6: restart yields a full first pulse
    bank_dis[1] = 1'b0;
    seen = 0; burst = 0;
    for (int k = 0; k < 30; k++) begin
      tick(1);
      if (bank_clk[1]) begin seen = 1; if (burst >= 0) burst++; end
      else if (seen && burst > 0) burst = -burst;
    end
    check("R6 first pulse length", (burst < 0) ? -burst : burst, 3);

    // R3/R11: float mode latency
    mode = 2'b10;
    tick(2);
    bank_dis[0] = 1'b1;
    tick(2);
    check("R11 drive_en before sync", drive_en[0], 1);
    tick(1);
    check("R3 drive_en floated", drive_en[0], 0);
    check("R3 other bank driven", drive_en[1], 1);
    bank_dis[0] = 1'b0;
    tick(5);
    check("R3 drive_en restored", drive_en[0], 1);

    // R7: test mode ignores bank0 disable
    mode = 2'b01;
    bank_dis[0] = 1'b1;
    highs = 0;
    for (int k = 0; k < 20; k++) begin tick(1); highs += bank_clk[0]; end
    check("R7 bank0 still clocks", int'(highs >= 8), 1);
    check("R7 drive_en unchanged", drive_en, 3);

    // R8/R9/R10: test reset sequence
    bank_dis[1] = 1'b1;
    tick(3);
    check("R8 all floated", drive_en, 0);
    check("R9 hold before edges", fsm_hold, 0);
    repeat (4) ref_pulse();
    tick(4);
    check("R9 hold after four edges", fsm_hold, 0);
    ref_pulse();
    check("R9 hold after fifth edge", fsm_hold, 1);
    repeat (3) ref_pulse();
    check("R9 hold saturates", fsm_hold, 1);
    check("R10 still floated", drive_en, 0);
    bank_dis[1] = 1'b0;
    tick(5);
    check("R10 hold released", fsm_hold, 0);
    check("R10 drive restored", drive_en, 3);
    bank_dis[1] = 1'b1;
    tick(3);
    repeat (4) ref_pulse();
    tick(4);
    check("R10 count cleared", fsm_hold, 0);
    bank_dis[1] = 1'b0;
    tick(5);

    // R7: second test code
    mode = 2'b11;
    tick(4);
    check("R7 open code drive", drive_en, 3);
    bank_dis[1] = 1'b1;
    tick(4);
    check("R8 open code floats", drive_en, 0);
    bank_dis = 2'b00;
    mode = 2'b00;
    tick(20);
    check("R2 back to normal", drive_en, 3);
    finish_run();
  end

endmodule